// File: doc/BRIEF.md
# Register Save/Restore Stack Sequencer

This block saves and restores a group of eight general-purpose registers to and from a stack in memory. The stack grows toward lower addresses. It also performs a single push or a single pop of one register. The block owns the stack pointer. It reaches the rest of the register file through one read/write port, and it issues at most one memory access per clock. Each access completes on an edge where the memory raises its ready input.

A command carries an operation, a register index and an operand-size flag. In full-size mode each stack slot is `DATA_W/8` bytes wide. In half-size mode each slot is `DATA_W/16` bytes wide, and only the low half of each register is moved. Register index 4 is the stack pointer. The block never writes it through the register port: a block save stores a copy of the pointer taken when the command was accepted, and a block restore reads that slot and throws it away.

Top module: `stk_seq`

## Requirements
- R1: While reset is low and after it is released, `busy` and `done` are 0, `mem_req` is 0 and `stack_ptr` equals the parameter `SP_RESET`.
- R2: `cmd_op` encodes 0 = push one register, 1 = pop one register, 2 = save all eight, 3 = restore all eight. A command is accepted on a rising edge with `cmd_valid` high and `busy` low. A command offered while `busy` is high has no effect on memory traffic, register writes or the stack pointer.
- R3: A single push writes register `cmd_reg` to address `stack_ptr - step` with `mem_we` = 1, and leaves `stack_ptr` lowered by `step`. Here `step` is 4 in full mode and 2 in half mode, for `DATA_W` = 32.
- R4: A single pop reads address `stack_ptr`, writes the value to register `cmd_reg`, and leaves `stack_ptr` raised by `step`.
- R5: A save-all writes registers 0, 1, 2, 3, the stack pointer value captured at acceptance, then 5, 6 and 7, each at an address `step` lower than the one before. The first address is `start - step`.
- R6: A restore-all reads eight consecutive slots upward from `stack_ptr` and writes them to registers 7, 6, 5, nothing, 3, 2, 1, 0. The fourth slot is read but discarded.
- R7: After a save-all `stack_ptr` equals the start value minus `8*step`. After a restore-all it equals the start value plus `8*step`.
- R8: For index 4, a single push stores the pointer value held before the decrement. A single pop loads `stack_ptr` with the popped value, zero-extended. `rf_we` is never high with `rf_idx` = 4.
- R9: In half mode, `mem_half` and `rf_half` are 1. Pushed data carries the register's low half with the upper half zero. Register writes carry the popped low half, zero-extended.
- R10: A slot completes on each edge where `mem_ready` is high. While `mem_ready` is low the access and the pointer hold. With `mem_ready` held high, `done` is seen N clock cycles after acceptance, where N is 1 for single operations and 8 for block operations.
- R11: `done` is a one-cycle pulse, and `busy` is low in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | Operation code (see R2) |
| cmd_reg | input | 3 | Register index for single push/pop |
| cmd_half | input | 1 | 1 = half-size operands |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| stack_ptr | output | ADDR_W | Current stack pointer |
| rf_idx | output | 3 | Register port index |
| rf_rdata | input | DATA_W | Register read data, combinational on rf_idx |
| rf_we | output | 1 | Register write enable |
| rf_half | output | 1 | Write only the low half of the register |
| rf_wdata | output | DATA_W | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_half | output | 1 | Access is half width |
| mem_addr | output | ADDR_W | Byte address of the slot |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes at this edge |

## Verification
The bench builds the block with `DATA_W` = 32, `ADDR_W` = 16 and `SP_RESET` = 0x0080. The narrow pointer selects the variant that zero-extends the captured pointer into a data word and truncates a popped word into the pointer. With these values, a pop into index 4 can move the stack to a new base that the bench chooses, and a block save can then be checked against that base. A 256-byte memory model covers every address that the save/restore sequences reach. Pseudo-random `mem_ready` stalls in half mode show that slots and the pointer hold steady through a stall.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

   typedef enum logic [1:0] {
      OP_PUSH     = 2'd0,
      OP_POP      = 2'd1,
      OP_PUSH_ALL = 2'd2,
      OP_POP_ALL  = 2'd3
   } stk_op_e;

   localparam int unsigned NUM_GPR = 8;
   localparam int unsigned SLOT_W  = $clog2(NUM_GPR);
   localparam logic [SLOT_W-1:0] SP_IDX = SLOT_W'(4);

endpackage

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
   import stk_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [SLOT_W-1:0] cmd_reg,
   input  logic              cmd_half,
   input  logic              beat,
   output logic              start,
   output logic              busy,
   output logic              done,
   output logic              last,
   output stk_op_e           op_q,
   output logic [SLOT_W-1:0] reg_q,
   output logic              half_q,
   output logic [SLOT_W-1:0] slot
);

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_GPR - 1);

   logic multi;

   assign start = cmd_valid & ~busy;
   assign multi = (op_q == OP_PUSH_ALL) || (op_q == OP_POP_ALL);
   assign last  = multi ? (slot == LAST_SLOT) : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         op_q   <= OP_PUSH;
         reg_q  <= '0;
         half_q <= 1'b0;
         slot   <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy   <= 1'b1;
            op_q   <= stk_op_e'(cmd_op);
            reg_q  <= cmd_reg;
            half_q <= cmd_half;
            slot   <= '0;
         end else if (beat) begin
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               slot <= slot + SLOT_W'(1);
            end
         end
      end
   end

   // R2
   cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !(beat && last) |=> busy && $stable(op_q) && $stable(reg_q) && $stable(half_q));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && beat && last |=> done && !busy);

endmodule

// File: rtl/stk_seq_order.sv
module stk_seq_order
   import stk_seq_pkg::*;
(
   input  stk_op_e           op,
   input  logic [SLOT_W-1:0] reg_sel,
   input  logic [SLOT_W-1:0] slot,
   output logic [SLOT_W-1:0] idx,
   output logic              sp_slot
);

   localparam logic [SLOT_W-1:0] TOP_IDX = SLOT_W'(NUM_GPR - 1);

   always_comb begin
      unique case (op)
         OP_PUSH_ALL: idx = slot;
         OP_POP_ALL:  idx = TOP_IDX - slot;
         default:     idx = reg_sel;
      endcase
   end

   assign sp_slot = (idx == SP_IDX);

endmodule

// File: rtl/stk_seq_sp.sv
module stk_seq_sp #(
   parameter int unsigned       DATA_W   = 32,
   parameter int unsigned       ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] SP_RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              half,
   input  logic              beat,
   input  logic              is_push,
   input  logic              sp_load,
   input  logic [DATA_W-1:0] load_val,
   output logic [ADDR_W-1:0] sp,
   output logic [ADDR_W-1:0] snap,
   output logic [ADDR_W-1:0] step,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] snap_word
);

   localparam int unsigned FULL_STEP = DATA_W / 8;
   localparam int unsigned HALF_STEP = DATA_W / 16;

   logic [ADDR_W-1:0] load_ptr;

   if ((DATA_W < 16) || (DATA_W % 16 != 0)) begin : g_bad_data_w
      $error("stk_seq_sp: DATA_W must be a positive multiple of 16");
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("stk_seq_sp: ADDR_W must be at least 4");
   end

   if (ADDR_W == DATA_W) begin : g_ptr_same
      assign snap_word = snap;
      assign load_ptr  = load_val;
   end else if (ADDR_W > DATA_W) begin : g_ptr_wide
      assign snap_word = snap[DATA_W-1:0];
      assign load_ptr  = {{(ADDR_W-DATA_W){1'b0}}, load_val};
   end else begin : g_ptr_narrow
      assign snap_word = {{(DATA_W-ADDR_W){1'b0}}, snap};
      assign load_ptr  = load_val[ADDR_W-1:0];
   end

   assign step = half ? ADDR_W'(HALF_STEP) : ADDR_W'(FULL_STEP);
   assign addr = is_push ? (sp - step) : sp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp   <= SP_RESET;
         snap <= SP_RESET;
      end else begin
         if (start) begin
            snap <= sp;
         end
         if (beat) begin
            if (sp_load) begin
               sp <= load_ptr;
            end else if (is_push) begin
               sp <= sp - step;
            end else begin
               sp <= sp + step;
            end
         end
      end
   end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
   import stk_seq_pkg::*;
#(
   parameter int unsigned       DATA_W   = 32,
   parameter int unsigned       ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] SP_RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [2:0]        cmd_reg,
   input  logic              cmd_half,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] stack_ptr,
   output logic [2:0]        rf_idx,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic              rf_we,
   output logic              rf_half,
   output logic [DATA_W-1:0] rf_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_half,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready
);

   localparam int unsigned HALF_W = DATA_W / 2;

   stk_op_e           op_q;
   logic [SLOT_W-1:0] reg_q;
   logic [SLOT_W-1:0] slot;
   logic              half_q;
   logic              start;
   logic              last;
   logic              beat;
   logic              is_push;
   logic              sp_slot;
   logic              sp_load;
   logic [ADDR_W-1:0] snap;
   logic [ADDR_W-1:0] step;
   logic [DATA_W-1:0] snap_word;
   logic [DATA_W-1:0] push_src;
   logic [DATA_W-1:0] pop_val;

   assign beat    = busy & mem_ready;
   assign is_push = (op_q == OP_PUSH) || (op_q == OP_PUSH_ALL);

   stk_seq_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_reg   (cmd_reg),
      .cmd_half  (cmd_half),
      .beat      (beat),
      .start     (start),
      .busy      (busy),
      .done      (done),
      .last      (last),
      .op_q      (op_q),
      .reg_q     (reg_q),
      .half_q    (half_q),
      .slot      (slot)
   );

   stk_seq_order u_order (
      .op      (op_q),
      .reg_sel (reg_q),
      .slot    (slot),
      .idx     (rf_idx),
      .sp_slot (sp_slot)
   );

   assign sp_load = beat && (op_q == OP_POP) && sp_slot;

   stk_seq_sp #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .SP_RESET (SP_RESET)
   ) u_sp (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .half      (half_q),
      .beat      (beat),
      .is_push   (is_push),
      .sp_load   (sp_load),
      .load_val  (pop_val),
      .sp        (stack_ptr),
      .snap      (snap),
      .step      (step),
      .addr      (mem_addr),
      .snap_word (snap_word)
   );

   // push data: the captured pointer replaces the register-file value at index 4
   assign push_src  = sp_slot ? snap_word : rf_rdata;
   assign mem_wdata = half_q ? {{HALF_W{1'b0}}, push_src[HALF_W-1:0]} : push_src;
   assign pop_val   = half_q ? {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]} : mem_rdata;

   assign mem_req  = busy;
   assign mem_we   = busy & is_push;
   assign mem_half = half_q;

   assign rf_we    = beat && !is_push && !sp_slot;
   assign rf_half  = half_q;
   assign rf_wdata = pop_val;

   // R7
   push_all_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && (op_q == OP_PUSH_ALL) |-> stack_ptr == snap - (step << 3));

   // R7
   pop_all_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && (op_q == OP_POP_ALL) |-> stack_ptr == snap + (step << 3));

   // R8
   no_sp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> rf_idx != SP_IDX);

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !mem_ready |=> busy && $stable(stack_ptr) && $stable(mem_addr));

endmodule

// File: tb/test_stk_seq.sv
module test_stk_seq;

   localparam int unsigned DW  = 32;
   localparam int unsigned AW  = 16;
   localparam logic [AW-1:0] SPR = 16'h0080;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'd0;
   logic [2:0]    cmd_reg = 3'd0;
   logic          cmd_half = 1'b0;
   logic          busy, done;
   logic [AW-1:0] stack_ptr;
   logic [2:0]    rf_idx;
   logic [DW-1:0] rf_rdata = '0;
   logic          rf_we, rf_half;
   logic [DW-1:0] rf_wdata;
   logic          mem_req, mem_we, mem_half;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_ready = 1'b1;

   always #4 clk = ~clk;

   stk_seq #(.DATA_W(DW), .ADDR_W(AW), .SP_RESET(SPR)) i_stk_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_reg(cmd_reg), .cmd_half(cmd_half), .busy(busy), .done(done),
      .stack_ptr(stack_ptr), .rf_idx(rf_idx), .rf_rdata(rf_rdata),
      .rf_we(rf_we), .rf_half(rf_half), .rf_wdata(rf_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_half(mem_half),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ready(mem_ready)
   );

   typedef struct {
      logic          we;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic          half;
   } mexp_t;

   typedef struct {
      logic [2:0]    idx;
      logic [DW-1:0] data;
      logic          half;
   } rexp_t;

   mexp_t mq[$];
   rexp_t rq[$];

   logic [7:0]    mem [0:255];
   logic [DW-1:0] rf  [0:7];
   logic [DW-1:0] saved [0:7];
   logic [AW-1:0] exp_sp = SPR;
   logic [7:0]    lfsr = 8'hA5;
   bit            stall_on = 1'b0;
   int            n_tests = 0;
   int            n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] rd_mem(input logic [AW-1:0] a, input bit h);
      logic [7:0] i = a[7:0];
      if (h) return {16'h0, mem[i+8'd1], mem[i]};
      return {mem[i+8'd3], mem[i+8'd2], mem[i+8'd1], mem[i]};
   endfunction

   // memory and register file models update at the edge
   always @(posedge clk) begin
      if (mem_req && mem_ready && mem_we) begin
         mem[mem_addr[7:0]]      = mem_wdata[7:0];
         mem[mem_addr[7:0]+8'd1] = mem_wdata[15:8];
         if (!mem_half) begin
            mem[mem_addr[7:0]+8'd2] = mem_wdata[23:16];
            mem[mem_addr[7:0]+8'd3] = mem_wdata[31:24];
         end
      end
      if (rf_we) begin
         if (rf_half) rf[rf_idx][15:0] = rf_wdata[15:0];
         else         rf[rf_idx] = rf_wdata;
      end
   end

   // monitor: drive ready, supply read data, compare against the scoreboard
   always @(negedge clk) begin
      mexp_t m;
      rexp_t r;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = stall_on ? (lfsr[0] | lfsr[2]) : 1'b1;
      #1;
      mem_rdata = rd_mem(mem_addr, mem_half);
      rf_rdata  = rf[rf_idx];
      #1;
      if (rst_n && mem_req && mem_ready) begin
         if (mq.size() == 0) begin
            chk(1'b0, "R2", "unexpected memory access at", 64'(mem_addr), 64'hFFFF);
         end else begin
            m = mq.pop_front();
            chk(mem_we == m.we, "R3", "access direction", 64'(mem_we), 64'(m.we));
            chk(mem_addr == m.addr, "R5", "slot address", 64'(mem_addr), 64'(m.addr));
            chk(mem_half == m.half, "R9", "access size", 64'(mem_half), 64'(m.half));
            if (m.we)
               chk(mem_wdata == m.data, "R5", "pushed data", 64'(mem_wdata), 64'(m.data));
         end
      end
      if (rst_n && rf_we) begin
         if (rq.size() == 0) begin
            chk(1'b0, "R6", "unexpected register write idx", 64'(rf_idx), 64'hF);
         end else begin
            r = rq.pop_front();
            chk(rf_idx == r.idx, "R6", "restore order", 64'(rf_idx), 64'(r.idx));
            chk(rf_wdata == r.data, "R4", "popped data", 64'(rf_wdata), 64'(r.data));
            chk(rf_half == r.half, "R9", "write size", 64'(rf_half), 64'(r.half));
         end
      end
   end

   // driver: predict traffic, issue command, wait for completion
   task automatic run(input logic [1:0] op, input logic [2:0] rsel, input bit h, input bit poke);
      logic [AW-1:0] step = h ? AW'(2) : AW'(4);
      logic [AW-1:0] snap = exp_sp;
      logic [DW-1:0] src, val;
      logic [2:0]    idx;
      int            slots = op[1] ? 8 : 1;
      int            cyc = 0;
      for (int k = 0; k < slots; k++) begin
         idx = op[1] ? (op[0] ? 3'(7 - k) : 3'(k)) : rsel;
         if (!op[0]) begin
            src = (idx == 3'd4) ? DW'(snap) : rf[idx];
            if (h) src = {16'h0, src[15:0]};
            exp_sp = exp_sp - step;
            mq.push_back('{we: 1'b1, addr: exp_sp, data: src, half: h});
         end else begin
            val = rd_mem(exp_sp, h);
            mq.push_back('{we: 1'b0, addr: exp_sp, data: '0, half: h});
            if (idx != 3'd4) rq.push_back('{idx: idx, data: val, half: h});
            exp_sp = exp_sp + step;
            if (!op[1] && idx == 3'd4) exp_sp = val[AW-1:0];
         end
      end
      @(negedge clk);
      cmd_op = op; cmd_reg = rsel; cmd_half = h; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      do begin
         @(negedge clk);
         cyc++;
         if (poke && cyc == 2) begin
            cmd_op = 2'd1; cmd_reg = 3'd0; cmd_half = 1'b0; cmd_valid = 1'b1;
         end
         if (poke && cyc == 3) cmd_valid = 1'b0;
      end while (!done && cyc < 400);
      chk(done, "R10", "completion seen", 64'(done), 64'd1);
      chk(!busy, "R11", "busy low with done", 64'(busy), 64'd0);
      if (!stall_on) chk(cyc == slots, "R10", "cycles to done", 64'(cyc), 64'(slots));
      chk(stack_ptr == exp_sp, "R7", "stack pointer after command", 64'(stack_ptr), 64'(exp_sp));
      @(negedge clk);
      chk(!done, "R11", "done is one cycle", 64'(done), 64'd0);
      chk(mq.size() == 0, "R2", "memory accesses left unseen", 64'(mq.size()), 64'd0);
      chk(rq.size() == 0, "R6", "register writes left unseen", 64'(rq.size()), 64'd0);
   endtask

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      for (int i = 0; i < 8; i++) rf[i] = 32'hA000_0000 + 32'(i * 32'h0101_1111);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done, "R1", "busy/done in reset", 64'({busy, done}), 64'd0);
      chk(!mem_req, "R1", "no request in reset", 64'(mem_req), 64'd0);
      chk(stack_ptr == SPR, "R1", "reset pointer", 64'(stack_ptr), 64'(SPR));
      rst_n = 1'b1;
      @(negedge clk);
      chk(stack_ptr == SPR && !busy, "R1", "pointer after release", 64'(stack_ptr), 64'(SPR));

      // R5 / R10 full-size save
      for (int i = 0; i < 8; i++) saved[i] = rf[i];
      run(2'd2, 3'd0, 1'b0, 1'b0);
      // R6: scramble registers and the pointer slot, then restore
      for (int i = 0; i < 8; i++) if (i != 4) rf[i] = 32'h0;
      mem[8'(SPR - 16'd20)] = 8'h5A;
      mem[8'(SPR - 16'd19)] = 8'hC3;
      run(2'd3, 3'd0, 1'b0, 1'b0);
      for (int i = 0; i < 8; i++)
         if (i != 4) chk(rf[i] == saved[i], "R6", "restored register", 64'(rf[i]), 64'(saved[i]));
      chk(stack_ptr == SPR, "R7", "pointer back to start", 64'(stack_ptr), 64'(SPR));

      // R9 half-size save/restore with stalls; R2 command poked while busy
      stall_on = 1'b1;
      for (int i = 0; i < 8; i++) rf[i] = 32'h7700_0000 | 32'(16'h1234 + 16'(i * 16'h1111));
      run(2'd2, 3'd0, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) if (i != 4) rf[i] = 32'h7700_0000;
      run(2'd3, 3'd0, 1'b1, 1'b1);
      for (int i = 0; i < 8; i++)
         if (i != 4) chk(rf[i] == (32'h7700_0000 | 32'(16'h1234 + 16'(i * 16'h1111))),
                         "R9", "half restore keeps upper half", 64'(rf[i]), 64'h0);
      stall_on = 1'b0;

      // R3 / R4 / R8 single operations
      rf[2] = 32'hDEAD_BEEF;
      run(2'd0, 3'd2, 1'b0, 1'b0);
      run(2'd0, 3'd4, 1'b0, 1'b0);
      run(2'd1, 3'd6, 1'b0, 1'b0);
      chk(rf[6] == 32'(SPR - 16'd4), "R8", "pushed pointer value", 64'(rf[6]), 64'(SPR - 16'd4));
      run(2'd1, 3'd1, 1'b0, 1'b0);
      chk(rf[1] == 32'hDEAD_BEEF, "R4", "single pop value", 64'(rf[1]), 64'hDEAD_BEEF);
      rf[3] = 32'h1111_ABCD;
      run(2'd0, 3'd3, 1'b1, 1'b0);
      rf[7] = 32'h9999_0000;
      run(2'd1, 3'd7, 1'b1, 1'b0);
      chk(rf[7] == 32'h9999_ABCD, "R9", "half single pop", 64'(rf[7]), 64'h9999_ABCD);

      // R8 pop into the pointer moves the stack; then a save from there (R5)
      rf[5] = 32'h0000_00C0;
      run(2'd0, 3'd5, 1'b0, 1'b0);
      run(2'd1, 3'd4, 1'b0, 1'b0);
      chk(stack_ptr == 16'h00C0, "R8", "pointer loaded by pop", 64'(stack_ptr), 64'h00C0);
      run(2'd2, 3'd0, 1'b0, 1'b1);
      chk(rd_mem(16'h00C0 - 16'd20, 1'b0) == 32'h0000_00C0, "R5", "captured pointer slot",
          64'(rd_mem(16'h00C0 - 16'd20, 1'b0)), 64'h00C0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule